// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block is a one-word-per-line, direct-mapped cache between a processor word port and a slower main-memory word port. It has eight lines of 32-bit data and serves a 256-word memory. Each line stores a tag, a valid flag and a dirty flag. Read misses fetch the word from memory. A line that was modified in the cache is copied back to memory before another address takes its slot.

The processor holds `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady until it sees `cpu_ready` high at a rising clock edge. That edge completes the access, and for reads `cpu_rdata` is valid in that same cycle. A hit completes in the cycle it is presented. A miss holds `cpu_ready` low while memory traffic runs.

The memory side raises `mem_req` with `mem_we`, `mem_addr` and `mem_wdata`, and holds them until a one-cycle `mem_ack`. For reads, `mem_ack` carries `mem_rdata`.

The parameter `WRITE_ALLOC` picks the write-miss policy. When it is 1, the line is fetched and then written in the cache. When it is 0, the word goes straight to memory and the cache is left alone.

Top module: `dm_wb_cache`

## Requirements
- R1: While `rst_n` is low, every line's valid and dirty flags clear. The first access to any address after reset is therefore a miss that issues a memory read, even if the stored tag would match.
- R2: The word address is split into an index (`cpu_addr[2:0]`, which picks the line) and a tag (`cpu_addr[7:3]`). Two addresses with the same index and different tags compete for one line.
- R3: A read hit raises `cpu_ready` in the cycle the request is presented and returns the stored word on `cpu_rdata`. It issues no memory request.
- R4: A read miss on a line that is invalid or clean fetches the word at `cpu_addr` from memory. It then installs the word with valid set and dirty clear, and completes as a hit on the following cycle.
- R5: A write hit completes in the cycle it is presented. It updates only the cache word and sets that line's dirty flag. Memory is not written.
- R6: A miss whose line is valid and dirty first writes the stored word to memory at {stored tag, index}. Only after that write is acknowledged does it read the new word.
- R7: A miss whose line is clean or invalid issues no memory write before the fill.
- R8: With `WRITE_ALLOC`=1, a write miss fills the line from memory and then writes the new word into the cache, leaving the line dirty. Memory keeps its old value until that line is evicted.
- R9: With `WRITE_ALLOC`=0, a write miss writes `cpu_wdata` to memory at `cpu_addr` and leaves every cache line unchanged. A write hit still behaves as in R5.
- R10: `cpu_ready` is low in every cycle that `mem_req` is high. Once `mem_req` rises, it stays high with `mem_addr` and `mem_we` unchanged until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until completion |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 8 | Processor word address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_ready | output | 1 | Access completes at this edge |
| cpu_rdata | output | 32 | Read data, valid when `cpu_ready` is high for a read |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 8 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | One-cycle completion of the memory transaction |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
The bench replays a conflict between two addresses that share an index. A design that dropped the dirty flag would lose the modified word. A design that rebuilt the victim address from the new tag would write it to the wrong location. A design that fetched before writing back would show the wrong order of memory operations.

It also checks that a clean victim causes no memory write, and that a write hit leaves memory untouched. A write-through design, or one that sets dirty on a fill, would fail these checks.

The two write-miss policies are run on separate instances. Allocating in the no-allocate mode would evict the resident line, which the bench sees as a later miss. A reset in the middle of the run must force a refetch even though the stored tag still matches.

// File: rtl/dm_wb_cache_pkg.sv
package dm_wb_cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WBACK,
    ST_FILL,
    ST_AROUND,
    ST_DONE
  } cache_state_e;
endpackage

// File: rtl/cache_line_store.sv
module cache_line_store #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic              fill_en,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  new_tag,
  input  logic [DATA_W-1:0] new_data,
  output logic              line_valid,
  output logic              line_dirty,
  output logic [TAG_W-1:0]  line_tag,
  output logic [DATA_W-1:0] line_data,
  output logic [(1<<IDX_W)-1:0] valid_vec,
  output logic [(1<<IDX_W)-1:0] dirty_vec
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_a  [LINES];
  logic [DATA_W-1:0] data_a [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic              sel;
    logic              v_q, d_q;
    logic [TAG_W-1:0]  t_q;
    logic [DATA_W-1:0] w_q;

    assign sel = (idx == IDX_W'(g));

    // flags carry reset, payload does not
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else if (sel && fill_en) begin
        v_q <= 1'b1;
        d_q <= 1'b0;
      end else if (sel && wr_en) begin
        d_q <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel && (fill_en || wr_en)) w_q <= new_data;
      if (sel && fill_en)            t_q <= new_tag;
    end

    assign valid_vec[g] = v_q;
    assign dirty_vec[g] = d_q;
    assign tag_a[g]     = t_q;
    assign data_a[g]    = w_q;
  end

  assign line_valid = valid_vec[idx];
  assign line_dirty = dirty_vec[idx];
  assign line_tag   = tag_a[idx];
  assign line_data  = data_a[idx];
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import dm_wb_cache_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int IDX_W       = 3,
  parameter int DATA_W      = 32,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic                    cpu_ready,
  input  logic                    mem_ack,
  input  logic [DATA_W-1:0]       mem_rdata,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [DATA_W-1:0]       mem_wdata,
  input  logic                    line_valid,
  input  logic                    line_dirty,
  input  logic [ADDR_W-IDX_W-1:0] line_tag,
  input  logic [DATA_W-1:0]       line_data,
  output logic                    fill_en,
  output logic                    wr_en,
  output logic [DATA_W-1:0]       new_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  cache_state_e state_q, state_d;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             hit;

  assign idx = cpu_addr[IDX_W-1:0];
  assign tag = cpu_addr[ADDR_W-1:IDX_W];
  assign hit = line_valid && (line_tag == tag);

  always_comb begin
    state_d   = state_q;
    cpu_ready = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cpu_addr;
    mem_wdata = cpu_wdata;
    fill_en   = 1'b0;
    wr_en     = 1'b0;
    new_data  = cpu_wdata;
    unique case (state_q)
      ST_IDLE: begin
        if (!cpu_req) begin
          cpu_ready = 1'b1;
        end else if (hit) begin
          cpu_ready = 1'b1;
          wr_en     = cpu_we;
        end else if (cpu_we && !WRITE_ALLOC) begin
          state_d = ST_AROUND;
        end else if (line_valid && line_dirty) begin
          state_d = ST_WBACK;
        end else begin
          state_d = ST_FILL;
        end
      end
      ST_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {line_tag, idx};
        mem_wdata = line_data;
        if (mem_ack) state_d = ST_FILL;
      end
      ST_FILL: begin
        mem_req  = 1'b1;
        new_data = mem_rdata;
        if (mem_ack) begin
          fill_en = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_AROUND: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) state_d = ST_DONE;
      end
      ST_DONE: begin
        cpu_ready = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
  parameter int ADDR_W      = 8,
  parameter int IDX_W       = 3,
  parameter int DATA_W      = 32,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;

  logic              line_valid, line_dirty, fill_en, wr_en;
  logic [TAG_W-1:0]  line_tag;
  logic [DATA_W-1:0] line_data, new_data;
  logic [LINES-1:0]  valid_vec, dirty_vec;

  cache_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx        (cpu_addr[IDX_W-1:0]),
    .fill_en    (fill_en),
    .wr_en      (wr_en),
    .new_tag    (cpu_addr[ADDR_W-1:IDX_W]),
    .new_data   (new_data),
    .line_valid (line_valid),
    .line_dirty (line_dirty),
    .line_tag   (line_tag),
    .line_data  (line_data),
    .valid_vec  (valid_vec),
    .dirty_vec  (dirty_vec)
  );

  cache_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W),
               .WRITE_ALLOC(WRITE_ALLOC)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_ready  (cpu_ready),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .line_valid (line_valid),
    .line_dirty (line_dirty),
    .line_tag   (line_tag),
    .line_data  (line_data),
    .fill_en    (fill_en),
    .wr_en      (wr_en),
    .new_data   (new_data)
  );

  assign cpu_rdata = line_data;
endmodule

// File: rtl/dm_wb_cache_chk.sv
module dm_wb_cache_chk #(
  parameter int ADDR_W      = 8,
  parameter int IDX_W       = 3,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic [(1<<IDX_W)-1:0] valid_vec,
  input logic [(1<<IDX_W)-1:0] dirty_vec
);
  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);

  p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_same_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[IDX_W-1:0] == cpu_addr[IDX_W-1:0]));

  p_fill_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=>
      (valid_vec[$past(mem_addr[IDX_W-1:0])] && !dirty_vec[$past(mem_addr[IDX_W-1:0])]));

  p_victim_dirty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && (mem_addr != cpu_addr)) |->
      (valid_vec[cpu_addr[IDX_W-1:0]] && dirty_vec[cpu_addr[IDX_W-1:0]]));

  p_noalloc_no_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (!cpu_we || WRITE_ALLOC));
endmodule

bind dm_wb_cache dm_wb_cache_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W),
                                   .WRITE_ALLOC(WRITE_ALLOC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_we    (cpu_we),
  .cpu_addr  (cpu_addr),
  .cpu_ready (cpu_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_ack   (mem_ack),
  .valid_vec (valid_vec),
  .dirty_vec (dirty_vec)
);

// File: tb/tb_dm_wb_cache.sv
module tb_mem_model #(parameter int LAT = 2) (
  input  logic        clk,
  input  logic        req,
  input  logic        we,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic        ack,
  output logic [31:0] rdata
);
  logic [31:0] mem [256];
  int cnt, rd_cnt, wr_cnt;
  logic last_we, prev_we;
  logic [7:0] last_waddr;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 + 32'(i);
    ack = 1'b0; cnt = 0; rd_cnt = 0; wr_cnt = 0;
    last_we = 1'b0; prev_we = 1'b0; last_waddr = '0; rdata = '0;
  end

  always @(posedge clk) begin
    if (ack) begin
      ack <= 1'b0;
      cnt <= 0;
    end else if (req) begin
      if (cnt == LAT - 1) begin
        ack     <= 1'b1;
        rdata   <= mem[addr];
        prev_we <= last_we;
        last_we <= we;
        if (we) begin
          mem[addr]  <= wdata;
          wr_cnt     <= wr_cnt + 1;
          last_waddr <= addr;
        end else begin
          rd_cnt <= rd_cnt + 1;
        end
      end else begin
        cnt <= cnt + 1;
      end
    end
  end
endmodule

module tb_dm_wb_cache;
  logic clk, rst_n;
  logic        cpu_req   [2];
  logic        cpu_we    [2];
  logic [7:0]  cpu_addr  [2];
  logic [31:0] cpu_wdata [2];
  logic        cpu_ready [2];
  logic [31:0] cpu_rdata [2];
  logic        mem_req   [2];
  logic        mem_we    [2];
  logic [7:0]  mem_addr  [2];
  logic [31:0] mem_wdata [2];
  logic        mem_ack   [2];
  logic [31:0] mem_rdata [2];

  int n_chk = 0, n_fail = 0, viol = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  dm_wb_cache #(.WRITE_ALLOC(1'b1)) dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req[0]), .cpu_we(cpu_we[0]), .cpu_addr(cpu_addr[0]),
    .cpu_wdata(cpu_wdata[0]), .cpu_ready(cpu_ready[0]), .cpu_rdata(cpu_rdata[0]),
    .mem_req(mem_req[0]), .mem_we(mem_we[0]), .mem_addr(mem_addr[0]),
    .mem_wdata(mem_wdata[0]), .mem_ack(mem_ack[0]), .mem_rdata(mem_rdata[0]));

  dm_wb_cache #(.WRITE_ALLOC(1'b0)) dut_na (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req[1]), .cpu_we(cpu_we[1]), .cpu_addr(cpu_addr[1]),
    .cpu_wdata(cpu_wdata[1]), .cpu_ready(cpu_ready[1]), .cpu_rdata(cpu_rdata[1]),
    .mem_req(mem_req[1]), .mem_we(mem_we[1]), .mem_addr(mem_addr[1]),
    .mem_wdata(mem_wdata[1]), .mem_ack(mem_ack[1]), .mem_rdata(mem_rdata[1]));

  tb_mem_model #(.LAT(2)) mem_a (
    .clk(clk), .req(mem_req[0]), .we(mem_we[0]), .addr(mem_addr[0]),
    .wdata(mem_wdata[0]), .ack(mem_ack[0]), .rdata(mem_rdata[0]));

  tb_mem_model #(.LAT(2)) mem_b (
    .clk(clk), .req(mem_req[1]), .we(mem_we[1]), .addr(mem_addr[1]),
    .wdata(mem_wdata[1]), .ack(mem_ack[1]), .rdata(mem_rdata[1]));

  function automatic logic [31:0] pat(input logic [7:0] a);
    return 32'hC0DE_0000 + 32'(a);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R10 monitor: processor must never see ready during memory traffic
  always @(negedge clk) begin
    if (rst_n) begin
      for (int s = 0; s < 2; s++)
        if (mem_req[s] && cpu_ready[s]) viol++;
    end
  end

  task automatic access(input int s, input logic we, input logic [7:0] a,
                        input logic [31:0] wd, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    cpu_req[s] = 1'b1; cpu_we[s] = we; cpu_addr[s] = a; cpu_wdata[s] = wd;
    cyc = 0;
    #1;
    while (!cpu_ready[s]) begin
      @(negedge clk);
      #1;
      cyc++;
    end
    rd = cpu_rdata[s];
    @(posedge clk);
    #1;
    cpu_req[s] = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    logic [31:0] rd; int cyc, r0;
    #1;
    chk("R1 ready idle after reset", 32'(cpu_ready[0]), 32'd1);
    chk("R1 no mem req after reset", 32'(mem_req[0]), 32'd0);
    r0 = mem_a.rd_cnt;
    access(0, 1'b0, 8'h05, '0, rd, cyc);
    chk("R1 first access misses", 32'(mem_a.rd_cnt - r0), 32'd1);
    chk("R4 miss returns memory word", rd, pat(8'h05));
  endtask

  task automatic t_read_hit();
    logic [31:0] rd; int cyc, r0;
    r0 = mem_a.rd_cnt;
    access(0, 1'b0, 8'h05, '0, rd, cyc);
    chk("R3 hit same cycle", 32'(cyc), 32'd0);
    chk("R3 hit data", rd, pat(8'h05));
    chk("R3 hit no mem read", 32'(mem_a.rd_cnt - r0), 32'd0);
  endtask

  task automatic t_write_hit();
    logic [31:0] rd; int cyc, w0;
    w0 = mem_a.wr_cnt;
    access(0, 1'b1, 8'h05, 32'h1111_AAAA, rd, cyc);
    chk("R5 write hit same cycle", 32'(cyc), 32'd0);
    chk("R5 write hit no mem write", 32'(mem_a.wr_cnt - w0), 32'd0);
    chk("R5 memory unchanged", mem_a.mem[8'h05], pat(8'h05));
    access(0, 1'b0, 8'h05, '0, rd, cyc);
    chk("R5 cache holds new word", rd, 32'h1111_AAAA);
  endtask

  task automatic t_dirty_evict();
    logic [31:0] rd; int cyc, r0, w0;
    r0 = mem_a.rd_cnt; w0 = mem_a.wr_cnt;
    access(0, 1'b0, 8'h0D, '0, rd, cyc);
    chk("R6 one write-back", 32'(mem_a.wr_cnt - w0), 32'd1);
    chk("R6 write-back address old tag", 32'(mem_a.last_waddr), 32'h05);
    chk("R6 write-back data", mem_a.mem[8'h05], 32'h1111_AAAA);
    chk("R6 write before read", {30'd0, mem_a.prev_we, mem_a.last_we}, 32'b10);
    chk("R2 conflicting tag refetched", 32'(mem_a.rd_cnt - r0), 32'd1);
    chk("R2 new tag data", rd, pat(8'h0D));
  endtask

  task automatic t_clean_evict();
    logic [31:0] rd; int cyc, r0, w0;
    r0 = mem_a.rd_cnt; w0 = mem_a.wr_cnt;
    access(0, 1'b0, 8'h15, '0, rd, cyc);
    chk("R7 clean victim no write", 32'(mem_a.wr_cnt - w0), 32'd0);
    chk("R7 fill read", 32'(mem_a.rd_cnt - r0), 32'd1);
    chk("R7 data", rd, pat(8'h15));
    chk("R10 miss waits for memory", 32'(cyc >= 2), 32'd1);
  endtask

  task automatic t_write_alloc();
    logic [31:0] rd; int cyc, r0, w0;
    r0 = mem_a.rd_cnt; w0 = mem_a.wr_cnt;
    access(0, 1'b1, 8'h22, 32'h2222_BBBB, rd, cyc);
    chk("R8 write miss fills", 32'(mem_a.rd_cnt - r0), 32'd1);
    chk("R8 no mem write on allocate", 32'(mem_a.wr_cnt - w0), 32'd0);
    chk("R8 memory still old", mem_a.mem[8'h22], pat(8'h22));
    access(0, 1'b0, 8'h22, '0, rd, cyc);
    chk("R8 allocated line hits", 32'(cyc), 32'd0);
    chk("R8 allocated data", rd, 32'h2222_BBBB);
    w0 = mem_a.wr_cnt;
    access(0, 1'b0, 8'h2A, '0, rd, cyc);
    chk("R8 allocated line dirty", 32'(mem_a.wr_cnt - w0), 32'd1);
    chk("R8 written back value", mem_a.mem[8'h22], 32'h2222_BBBB);
    chk("R8 evicting read data", rd, pat(8'h2A));
  endtask

  task automatic t_reset_again();
    logic [31:0] rd; int cyc, r0;
    do_reset();
    r0 = mem_a.rd_cnt;
    access(0, 1'b0, 8'h2A, '0, rd, cyc);
    chk("R1 reset invalidates matching tag", 32'(mem_a.rd_cnt - r0), 32'd1);
    chk("R1 refetched data", rd, pat(8'h2A));
  endtask

  task automatic t_no_alloc();
    logic [31:0] rd; int cyc, r0, w0;
    access(1, 1'b0, 8'h03, '0, rd, cyc);
    chk("R4 no-alloc fill", rd, pat(8'h03));
    r0 = mem_b.rd_cnt; w0 = mem_b.wr_cnt;
    access(1, 1'b1, 8'h0B, 32'h3333_CCCC, rd, cyc);
    chk("R9 write around writes memory", 32'(mem_b.wr_cnt - w0), 32'd1);
    chk("R9 write around no fill", 32'(mem_b.rd_cnt - r0), 32'd0);
    chk("R9 memory data", mem_b.mem[8'h0B], 32'h3333_CCCC);
    access(1, 1'b0, 8'h03, '0, rd, cyc);
    chk("R9 resident line kept", 32'(cyc), 32'd0);
    chk("R9 resident data", rd, pat(8'h03));
    r0 = mem_b.rd_cnt; w0 = mem_b.wr_cnt;
    access(1, 1'b0, 8'h0B, '0, rd, cyc);
    chk("R9 read sees written word", rd, 32'h3333_CCCC);
    chk("R7 no-alloc clean victim", 32'(mem_b.wr_cnt - w0), 32'd0);
    access(1, 1'b1, 8'h0B, 32'h4444_DDDD, rd, cyc);
    chk("R9 write hit in no-alloc", 32'(cyc), 32'd0);
    chk("R5 no-alloc write hit no mem write", 32'(mem_b.wr_cnt - w0), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    for (int s = 0; s < 2; s++) begin
      cpu_req[s] = 1'b0; cpu_we[s] = 1'b0; cpu_addr[s] = '0; cpu_wdata[s] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_read_hit();
    t_write_hit();
    t_dirty_evict();
    t_clean_evict();
    t_write_alloc();
    t_reset_again();
    t_no_alloc();
    chk("R10 ready low during memory traffic", 32'(viol), 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule